// File: doc/BRIEF.md
# Configurable Logic Block Tile

This block is one programmable logic cell of the kind repeated across a reconfigurable fabric. It holds two four-input lookup tables, named F and G, and a merge stage H that passes one of the two table results on to the next stage. Routing selectors decide which internal result drives the combinational outputs X and Y. Two flip-flops provide the registered outputs XQ and YQ, and a selector chooses the data input of each one. No part of the cell's behaviour is fixed in gates. Every table entry and every selector setting comes from a configuration word that is shifted in one bit per clock.

Configuration happens first. The user holds `cfg_en` high for 38 clocks and presents one configuration bit on `cfg_in` in each of those clocks. After that the user drives the eight table inputs, the H select, the direct data input and the clock enable. The cell then behaves as the loaded configuration describes. A synchronous reset clears the two flip-flops and leaves the configuration untouched.

Top module: `logic_cell_tile`

## Requirements
- R1: Output F is the entry of the 16-entry F table at index `f_in`. The F table occupies configuration bits 15..0, and bit n holds the entry for index n.
- R2: Output G is the entry of the 16-entry G table at index `g_in`. The G table occupies configuration bits 31..16, and bit 16+n holds the entry for index n.
- R3: H equals F when `h_sel` is 1 and equals G when `h_sel` is 0.
- R4: Configuration bit 32 selects the source of `x_out`: 0 gives F and 1 gives H. Configuration bit 33 selects the source of `y_out`: 0 gives G and 1 gives H.
- R5: While `cfg_en` is 1, each rising edge shifts `cfg_in` into the chain. After 38 shifts, the first bit shifted in sits at configuration bit 0 and the last sits at bit 37.
- R6: Configuration bits 35..34 select the data input of the XQ flip-flop, and bits 37..36 select that of the YQ flip-flop. In each pair the lower bit is shifted first. The field values select as follows: 0 = F, 1 = G, 2 = H, 3 = `d_in`.
- R7: When `cfg_en` is 0, `ce` is 1 and `rst` is 0, each flip-flop loads its selected data input on the rising edge. When `ce` is 0, both flip-flops hold their values.
- R8: While `cfg_en` is 1, both flip-flops hold their values.
- R9: When `rst` is 1 at a rising edge, `xq` and `yq` become 0 and the configuration keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the two flip-flops |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration bit |
| f_in | input | 4 | Index into the F table |
| g_in | input | 4 | Index into the G table |
| h_sel | input | 1 | Merge select: 1 passes F, 0 passes G |
| d_in | input | 1 | Direct data input that either flip-flop can load |
| ce | input | 1 | Clock enable for both flip-flops |
| x_out | output | 1 | Combinational output X |
| y_out | output | 1 | Combinational output Y |
| xq | output | 1 | Registered output of the X flip-flop |
| yq | output | 1 | Registered output of the Y flip-flop |

## Verification
Four properties are checked on every cycle. The first is that the flip-flops hold whenever `ce` is low or the chain is shifting. The second is that reset clears both flip-flops. The third is that the merge stage passes F or G as `h_sel` directs. The fourth is that a flip-flop set to load F or `d_in` captures that value. The bench scenarios cover what a property cannot reach: the serial load order and the resulting bit layout, every table entry under all 256 input pairs for several configurations, and the fact that a reset leaves the loaded configuration in place.

// File: rtl/lct_pkg.sv
`timescale 1ns/1ps
package lct_pkg;

    localparam int LUT_K      = 4;
    localparam int LUT_WORDS  = 1 << LUT_K;
    localparam int NUM_LUTS   = 2;
    localparam int DSEL_W     = 2;
    localparam int NUM_FFS    = 2;
    localparam int CFG_BITS   = NUM_LUTS * LUT_WORDS + 2 + NUM_FFS * DSEL_W;

    typedef enum logic [DSEL_W-1:0] {
        DSRC_F   = 2'd0,
        DSRC_G   = 2'd1,
        DSRC_H   = 2'd2,
        DSRC_DIN = 2'd3
    } dsrc_e;

    // Packed layout: the last field sits at bit 0 (first bit shifted in).
    typedef struct packed {
        dsrc_e                yq_src;
        dsrc_e                xq_src;
        logic                 y_from_h;
        logic                 x_from_h;
        logic [LUT_WORDS-1:0] g_tab;
        logic [LUT_WORDS-1:0] f_tab;
    } cfg_t;

    typedef struct packed {
        logic f;
        logic g;
        logic h;
        logic din;
    } nodes_t;

    function automatic logic pick_d(input dsrc_e s, input nodes_t n);
        logic r;
        unique case (s)
            DSRC_F:   r = n.f;
            DSRC_G:   r = n.g;
            DSRC_H:   r = n.h;
            default:  r = n.din;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lct_cfg_chain.sv
`timescale 1ns/1ps
module lct_cfg_chain #(
    parameter int N = 38
) (
    input  logic         clk,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [N-1:0] bits
);
    // New bit enters at the top; after N shifts the first bit reaches bit 0.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            bits <= {ser_in, bits[N-1:1]};
        end
    end
endmodule

// File: rtl/lct_lut.sv
`timescale 1ns/1ps
module lct_lut #(
    parameter int K = 4,
    localparam int WORDS = 1 << K
) (
    input  logic [WORDS-1:0] table_bits,
    input  logic [K-1:0]     addr,
    output logic             y
);
    always_comb begin
        y = table_bits[addr];
    end
endmodule

// File: rtl/lct_regbit.sv
`timescale 1ns/1ps
module lct_regbit (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic ce,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (!hold && ce) begin
            q <= d;
        end
    end
endmodule

// File: rtl/logic_cell_tile.sv
`timescale 1ns/1ps
module logic_cell_tile
    import lct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_in,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h_sel,
    input  logic             d_in,
    input  logic             ce,
    output logic             x_out,
    output logic             y_out,
    output logic             xq,
    output logic             yq
);

    logic [CFG_BITS-1:0] cfg_raw;
    cfg_t                cfg;
    logic [NUM_LUTS-1:0] lut_out;
    nodes_t              nodes;
    logic [NUM_FFS-1:0]  ff_d;
    logic [NUM_FFS-1:0]  ff_q;

    lct_cfg_chain #(.N(CFG_BITS)) u_chain (
        .clk      (clk),
        .shift_en (cfg_en),
        .ser_in   (cfg_in),
        .bits     (cfg_raw)
    );

    assign cfg = cfg_t'(cfg_raw);

    // Index 0 is F, index 1 is G.
    for (genvar i = 0; i < NUM_LUTS; i++) begin : g_lut
        lct_lut #(.K(LUT_K)) u_lut (
            .table_bits ((i == 0) ? cfg.f_tab : cfg.g_tab),
            .addr       ((i == 0) ? f_in : g_in),
            .y          (lut_out[i])
        );
    end

    always_comb begin
        nodes.f   = lut_out[0];
        nodes.g   = lut_out[1];
        nodes.h   = h_sel ? lut_out[0] : lut_out[1];
        nodes.din = d_in;
    end

    always_comb begin
        x_out = cfg.x_from_h ? nodes.h : nodes.f;
        y_out = cfg.y_from_h ? nodes.h : nodes.g;
    end

    // Index 0 is the X flip-flop, index 1 is the Y flip-flop.
    for (genvar j = 0; j < NUM_FFS; j++) begin : g_ff
        assign ff_d[j] = pick_d((j == 0) ? cfg.xq_src : cfg.yq_src, nodes);
        lct_regbit u_ff (
            .clk  (clk),
            .rst  (rst),
            .hold (cfg_en),
            .ce   (ce),
            .d    (ff_d[j]),
            .q    (ff_q[j])
        );
    end

    assign xq = ff_q[0];
    assign yq = ff_q[1];

endmodule

// File: rtl/lct_checker.sv
`timescale 1ns/1ps
module lct_checker
    import lct_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cfg_en,
    input logic  ce,
    input logic  h_sel,
    input logic  d_in,
    input logic  x_out,
    input logic  y_out,
    input logic  xq,
    input logic  yq,
    input logic  f_val,
    input logic  g_val,
    input logic  x_from_h,
    input logic  y_from_h,
    input dsrc_e xq_src,
    input dsrc_e yq_src
);

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (xq == 1'b0 && yq == 1'b0));

    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> $stable({xq, yq}));

    assert_ce_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable({xq, yq}));

    assert_h_passes_f_R3: assert property (@(posedge clk) disable iff (rst)
        (h_sel && x_from_h) |-> (x_out == f_val));

    assert_h_passes_g_R3: assert property (@(posedge clk) disable iff (rst)
        (!h_sel && y_from_h) |-> (y_out == g_val));

    assert_xq_loads_f_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && ce && xq_src == DSRC_F) |=> (xq == $past(f_val)));

    assert_yq_loads_din_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && ce && yq_src == DSRC_DIN) |=> (yq == $past(d_in)));

endmodule

bind logic_cell_tile lct_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .ce       (ce),
    .h_sel    (h_sel),
    .d_in     (d_in),
    .x_out    (x_out),
    .y_out    (y_out),
    .xq       (xq),
    .yq       (yq),
    .f_val    (lut_out[0]),
    .g_val    (lut_out[1]),
    .x_from_h (cfg.x_from_h),
    .y_from_h (cfg.y_from_h),
    .xq_src   (cfg.xq_src),
    .yq_src   (cfg.yq_src)
);

// File: tb/logic_cell_tile_bench.sv
`timescale 1ns/1ps
module logic_cell_tile_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_in = 1'b0;
    logic [3:0] f_in = '0;
    logic [3:0] g_in = '0;
    logic       h_sel = 1'b0;
    logic       d_in = 1'b0;
    logic       ce = 1'b0;
    logic       x_out, y_out, xq, yq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    logic_cell_tile u_logic_cell_tile (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
        .f_in(f_in), .g_in(g_in), .h_sel(h_sel), .d_in(d_in), .ce(ce),
        .x_out(x_out), .y_out(y_out), .xq(xq), .yq(yq)
    );

    typedef struct {
        bit    cc;
        bit    cr;
        bit    x, y, xq, yq;
        string tag;
    } item_t;

    item_t sb[$];

    // Bench model state
    logic [37:0] mcfg = '0;
    bit          mx = 0, my = 0;

    function automatic bit sel_d(input logic [1:0] s, input bit f, input bit g,
                                 input bit h, input bit dd);
        case (s)
            2'd0: return f;
            2'd1: return g;
            2'd2: return h;
            default: return dd;
        endcase
    endfunction

    function automatic void check(input string tag, input bit act, input bit exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp_v, $time);
        end
    endfunction

    // Driver: inputs already set at a falling edge; predict and push, then wait.
    task automatic drive_cycle(input bit cc, input bit cr, input string tag);
        item_t it;
        bit f, g, h;
        f = mcfg[f_in];
        g = mcfg[16 + g_in];
        h = h_sel ? f : g;
        it.cc  = cc;
        it.cr  = cr;
        it.x   = mcfg[32] ? h : f;
        it.y   = mcfg[33] ? h : g;
        if (rst) begin
            mx = 0; my = 0;
        end else if (!cfg_en && ce) begin
            mx = sel_d(mcfg[35:34], f, g, h, d_in);
            my = sel_d(mcfg[37:36], f, g, h, d_in);
        end
        it.xq  = mx;
        it.yq  = my;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // R5: serial load, bit 0 first; flip-flops must hold meanwhile (R8).
    task automatic load_cfg(input logic [37:0] c);
        for (int i = 0; i < 38; i++) begin
            cfg_en = 1'b1;
            cfg_in = c[i];
            ce     = 1'($urandom);
            drive_cycle(0, 1, "R8 hold during load");
        end
        cfg_en = 1'b0;
        mcfg   = c;
    endtask

    task automatic sweep(input int n, input string tag);
        for (int a = 0; a < n; a++) begin
            f_in  = a[3:0];
            g_in  = a[7:4];
            h_sel = 1'($urandom);
            d_in  = 1'($urandom);
            ce    = ($urandom % 4) != 0;
            drive_cycle(1, 1, tag);
        end
    endtask

    // Monitor: pops one expectation after every rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                if (it.cc) begin
                    check({it.tag, " R1/R3/R4/R5 x_out"}, x_out, it.x);
                    check({it.tag, " R2/R3/R4/R5 y_out"}, y_out, it.y);
                end
                if (it.cr) begin
                    check({it.tag, " R6/R7 xq"}, xq, it.xq);
                    check({it.tag, " R6/R7 yq"}, yq, it.yq);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [37:0] c;
        repeat (3) @(negedge clk);
        drive_cycle(0, 1, "R9 reset state");
        rst = 1'b0;
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: c = {2'd3, 2'd0, 1'b0, 1'b0, 16'h00FF, 16'h8001};
                1: c = {2'd2, 2'd1, 1'b1, 1'b1, 16'hA5C3, 16'h3C96};
                default: c = {6'($urandom), 32'($urandom)};
            endcase
            load_cfg(c);
            sweep(256, "cfg sweep");
            if (k == 2) begin
                rst = 1'b1;
                drive_cycle(0, 1, "R9 sync reset");
                rst = 1'b0;
                sweep(32, "R9 config retained");
            end
        end
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule